// File: doc/BRIEF.md
# Serial Single-MAC Four-Tap FIR Filter

This block is a four-tap finite impulse response filter. It produces each output as the sum of the four most recent input samples, each multiplied by its own coefficient. A parallel multiply-add tree would need four multipliers. This block instead shares one multiplier and one adder over time: a small controller visits one tap per clock cycle and adds that tap's product into an accumulator.

A sample is offered on `smp_data` with `smp_valid`. It is taken only while `in_ready` is high. Taking a sample shifts it into the delay line and starts a four-cycle computation. The finished sum appears on `out_data` with a one-cycle `out_valid` pulse. The coefficients come in on one flat input bus. The surrounding logic holds them stable while a computation runs.

The block takes at most one sample every five cycles: four busy cycles, then one cycle with `in_ready` high.

Top module: `serial_fir4`

## Requirements
- R1: When synchronous reset is high, the block clears the delay line, the accumulator, the tap counter, `out_data` and `out_valid` to zero. After reset, `in_ready` is high.
- R2: Each result equals S0·A0 + S1·A1 + S2·A2 + S3·A3.
  - Samples and coefficients are 16-bit signed two's complement.
  - S0 is the newest accepted sample and S3 is the oldest of the four.
  - A_k is `coef_flat[16k+15:16k]`.
- R3: Each accepted sample enters the delay line as S0. The older samples move one place toward S3, and the previous S3 is dropped.
- R4: `out_valid` is high for exactly one cycle per accepted sample. It is high on the fifth rising edge after the edge that accepted the sample, which is the cycle after the fourth product is accumulated.
- R5: After a sample is accepted, `in_ready` stays low for the next four cycles. A `smp_valid` that arrives while `in_ready` is low is ignored: the sample is not shifted in and no computation starts. While busy, the tap index steps through 0, 1, 2, 3, one per cycle.
- R6: The accumulator restarts with the tap-0 product at the start of every computation, so no earlier sum enters a new result.
- R7: `out_data` keeps its value on every cycle where `out_valid` is low.
- R8: `out_data` is 34 bits wide, which holds the sum of four full-scale products (up to 2^32 in magnitude) without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Offers a sample on `smp_data` |
| smp_data | input | 16 | Signed input sample |
| coef_flat | input | 64 | Coefficients; A_k in bits [16k+15:16k] |
| in_ready | output | 1 | High when a sample can be accepted |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 34 | Signed filter result, held between pulses |

## Verification
The assertions assume that reset is held for at least one clock edge before it is released. They also assume that `coef_flat` does not change while a computation is running, because the tap products read the coefficients live during the four busy cycles.

The stimulus changes the coefficients only after it has waited out the result of every accepted sample. It still holds `smp_valid` high through busy periods, so that the rule for ignoring samples is exercised. A reference model built from a sample history and countdown timers predicts `in_ready`, `out_valid` and `out_data`, and the bench compares them against the outputs on every cycle.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_COEF_W = 16;
  localparam int DEF_TAPS   = 4;

  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_t;
endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_en,
  input  logic [DATA_W-1:0]        din,
  output logic [TAPS*DATA_W-1:0]   taps_flat
);
  logic [DATA_W-1:0] stage_q [TAPS];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else if (shift_en) stage_q[0] <= din;
  end

  for (genvar g = 1; g < TAPS; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= '0;
      else if (shift_en) stage_q[g] <= stage_q[g-1];
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_out
    assign taps_flat[g*DATA_W +: DATA_W] = stage_q[g];
  end

  // R3: the newest sample lands in stage 0, the previous stage 0 moves to stage 1
  assert_shift_in_R3: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> taps_flat[DATA_W-1:0] == $past(din)
                 && taps_flat[2*DATA_W-1:DATA_W] == $past(taps_flat[DATA_W-1:0]));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(taps_flat));
endmodule

// File: rtl/fir_tap_ctrl.sv
module fir_tap_ctrl
  import fir_pkg::*;
#(
  parameter int TAPS  = 4,
  parameter int IDX_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             first,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAPS - 1);

  phase_t phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx     <= '0;
      done    <= 1'b0;
    end else begin
      done <= (phase_q == PH_RUN) && (idx == LAST_IDX);
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_RUN;
          idx     <= '0;
        end
        PH_RUN: if (idx == LAST_IDX) begin
          phase_q <= PH_IDLE;
          idx     <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy  = (phase_q == PH_RUN);
  assign first = busy && (idx == '0);

  // R5: taps are visited in ascending order, one per cycle
  assert_idx_step_R5: assert property (@(posedge clk) disable iff (rst)
    busy && idx != LAST_IDX |=> busy && idx == $past(idx) + 1'b1);
  assert_start_R5: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && idx == '0);
  assert_end_R5: assert property (@(posedge clk) disable iff (rst)
    busy && idx == LAST_IDX |=> !busy && done);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 34
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     first,
  input  logic signed [DATA_W-1:0] smp,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  acc
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  addend;

  assign prod     = smp * coef;
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign addend   = first ? '0 : acc;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (en) acc <= addend + prod_ext;
  end

  // R6: a new computation starts from the tap-0 product alone
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    en && first |=> acc == $past(prod_ext));
  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));
endmodule

// File: rtl/serial_fir4.sv
module serial_fir4
  import fir_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int COEF_W = DEF_COEF_W,
  parameter int TAPS   = DEF_TAPS,
  parameter int OUT_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_valid,
  input  logic [DATA_W-1:0]       smp_data,
  input  logic [TAPS*COEF_W-1:0]  coef_flat,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_data
);
  localparam int IDX_W = $clog2(TAPS);

  logic                     busy, first, done, accept;
  logic [IDX_W-1:0]         idx;
  logic [TAPS*DATA_W-1:0]   taps_flat;
  logic signed [DATA_W-1:0] sel_smp;
  logic signed [COEF_W-1:0] sel_coef;
  logic signed [OUT_W-1:0]  acc;

  assign in_ready = !busy;
  assign accept   = smp_valid && !busy;

  fir_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
    .clk(clk), .rst(rst), .shift_en(accept), .din(smp_data), .taps_flat(taps_flat)
  );

  fir_tap_ctrl #(.TAPS(TAPS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(smp_valid), .busy(busy), .idx(idx),
    .first(first), .done(done)
  );

  // operand selection: one sample/coefficient pair per cycle
  assign sel_smp  = taps_flat[idx*DATA_W +: DATA_W];
  assign sel_coef = coef_flat[idx*COEF_W +: COEF_W];

  fir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(OUT_W)) u_mac (
    .clk(clk), .rst(rst), .en(busy), .first(first),
    .smp(sel_smp), .coef(sel_coef), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= done;
      if (done) out_data <= acc;
    end
  end

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
  assert_ready_low_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> !out_valid && out_data == '0 && in_ready);
endmodule

// File: tb/serial_fir4_test.sv
module serial_fir4_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int TP = 4;
  localparam int OW = 34;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_valid = 1'b0;
  logic [DW-1:0]     smp_data = '0;
  logic [TP*DW-1:0]  coef_flat = '0;
  logic              in_ready, out_valid;
  logic [OW-1:0]     out_data;

  int tests = 0;
  int fails = 0;
  string cur_tag = "R2";
  bit checking = 1'b0;

  serial_fir4 uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .coef_flat(coef_flat), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: sample history plus countdown timers
  longint hist [TP];
  int     m_busy = 0;
  int     m_pend = 0;
  longint m_pend_val = 0;
  bit     m_valid = 1'b0;
  longint m_data = 0;

  function automatic longint coef_at(int k);
    return longint'($signed(coef_flat[k*DW +: DW]));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TP; k++) hist[k] = 0;
      m_busy = 0; m_pend = 0; m_valid = 1'b0; m_data = 0;
    end else begin
      bit acc_now;
      acc_now = smp_valid && (m_busy == 0);
      m_valid = 1'b0;
      if (m_pend > 0) begin
        m_pend--;
        if (m_pend == 0) begin m_valid = 1'b1; m_data = m_pend_val; end
      end
      if (m_busy > 0) m_busy--;
      if (acc_now) begin
        for (int k = TP-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'($signed(smp_data));
        m_pend_val = 0;
        for (int k = 0; k < TP; k++) m_pend_val += hist[k] * coef_at(k);
        m_pend = 5;
        m_busy = 4;
      end
    end
  end

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check("R5 in_ready", longint'(in_ready), longint'(m_busy == 0));
      check("R4 out_valid", longint'(out_valid), longint'(m_valid));
      check(m_valid ? cur_tag : "R7", longint'($signed(out_data)), m_data);
    end
  end

  task automatic drive(bit v, logic [DW-1:0] d);
    @(negedge clk);
    smp_valid = v;
    smp_data  = d;
  endtask

  task automatic send(logic [DW-1:0] d);
    drive(1'b1, d);
    drive(1'b0, '0);
    repeat (4) drive(1'b0, '0);
  endtask

  task automatic set_coefs(int a0, int a1, int a2, int a3);
    repeat (6) drive(1'b0, '0);
    coef_flat = {DW'(a3), DW'(a2), DW'(a1), DW'(a0)};
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state just after reset
    check("R1 in_ready", longint'(in_ready), 1);
    check("R1 out_valid", longint'(out_valid), 0);
    check("R1 out_data", longint'(out_data), 0);
    checking = 1'b1;

    // R2 with zero older samples after reset, then R3 impulse walk
    cur_tag = "R2";
    set_coefs(1, 2, 3, 4);
    send(16'd7);
    cur_tag = "R3";
    send(16'd1);
    send(16'd0);
    send(16'd0);
    send(16'd0);
    send(16'd0);

    // R5: valid held high through busy cycles
    cur_tag = "R5";
    set_coefs(-3, 5, -7, 11);
    for (int i = 0; i < 30; i++) drive(1'b1, DW'(i * 37 - 400));
    repeat (6) drive(1'b0, '0);

    // R8: full-scale magnitudes
    cur_tag = "R8";
    set_coefs(-32768, -32768, -32768, -32768);
    for (int i = 0; i < 4; i++) send(16'h8000);
    set_coefs(32767, 32767, 32767, 32767);
    for (int i = 0; i < 4; i++) send(16'h8000);
    for (int i = 0; i < 4; i++) send(16'h7fff);

    // R6: random samples, gaps and coefficient sets
    cur_tag = "R6";
    for (int blk = 0; blk < 8; blk++) begin
      set_coefs($urandom, $urandom, $urandom, $urandom);
      for (int i = 0; i < 12; i++) begin
        drive(1'b1, DW'($urandom));
        repeat ($urandom_range(0, 7)) drive(($urandom_range(0, 3) == 0), DW'($urandom));
      end
    end
    set_coefs(0, 0, 0, 0);
    repeat (4) drive(1'b0, '0);

    checking = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule